// File: doc/BRIEF.md
# Output Clock Reset Synchronizer

This block divides a fast sampling clock into a data-capture clock and a one-cycle data-valid strobe. It also lets several identical instances that share the sampling clock line up their output clock phase, using one shared alignment reset pulse. The reset may arrive at any moment, and the output clock goes straight to a parked level. Removal of the reset is taken in only on a falling sampling-clock edge. A short, mode-dependent wait then follows, after which a phase counter restarts from zero. Every instance that saw the same pulse therefore produces the same clock.

While a calibration is running, the alignment reset has no effect and a sticky error flag records the attempt. The output clock is also parked during calibration unless continuous running is enabled.

Top module: `clock_align_sync`

## Requirements
- R1: While `align_rst` is high and `cal_busy` is low, `dclk_out` equals the parked level `mode_ddr XOR edge_sel` within the same sampling half-cycle as the assertion, without waiting for a clock edge, and `word_valid` is low.
- R2: Removal of `align_rst` takes effect at the first falling edge of `smp_clk` after it. A removal that comes just after a falling edge waits for the next one, which delays the restart by one cycle.
- R3: Count the rising edges of `smp_clk` after the falling edge that captured the removal. The output restarts right after the 5th of these when `mode_demux`=1, `mode_ddr`=1 and `edge_sel`=0, and right after the 4th in every other mode. Before that point `word_valid` stays low.
- R4: After the restart, let j be the number of sampling cycles since the restart. In demultiplexed SDR mode (`mode_demux`=1, `mode_ddr`=0), `dclk_out` = bit 0 of j XOR `edge_sel`. In demultiplexed DDR mode it is bit 1 of j XOR `edge_sel`. In non-demultiplexed mode it is `smp_clk` XOR `edge_sel`.
- R5: `word_valid` is high for one sampling cycle at the start of each output-clock period: when j mod 2 = 0 (demux SDR) or j mod 4 = 0 (demux DDR). In non-demultiplexed mode it is high every cycle. It is never high in two consecutive cycles in a demultiplexed mode.
- R6: With `cal_busy`=1 and `keep_running`=0, `dclk_out` holds the parked level and `word_valid` is low. With `keep_running`=1, the clock keeps running through calibration.
- R7: An `align_rst` pulse while `cal_busy`=1 does not stop or park a running output clock.
- R8: `cal_err` powers up low and goes high on the rising edge after any cycle in which `align_rst` and `cal_busy` are both high. It stays high until a rising edge that samples `err_clr`=1 with no new violation. When both happen in the same cycle, the set wins.
- R9: Two instances with different power-up phase counter values produce identical `dclk_out` and `word_valid` on every half-cycle after a shared reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Fast sampling clock |
| align_rst | input | 1 | Asynchronous alignment reset, active high |
| mode_ddr | input | 1 | 1 = double data rate output, 0 = single |
| mode_demux | input | 1 | 1 = demultiplexed output, 0 = direct |
| edge_sel | input | 1 | Output edge select; 1 inverts clock phase |
| cal_busy | input | 1 | Calibration running flag |
| keep_running | input | 1 | Keep output clock running during calibration |
| err_clr | input | 1 | Clears the sticky calibration-reset error |
| dclk_out | output | 1 | Divided data-capture clock |
| word_valid | output | 1 | One-cycle strobe at start of each output period |
| cal_err | output | 1 | Sticky flag: reset attempted during calibration |

## Verification
The hardest case to reach is a reset removal that lands on the far side of a falling edge. The restart then slips by exactly one cycle, and from the ports this is only visible as a one-cycle shift of the first `word_valid`. The stimulus releases the reset once a nanosecond before a falling edge and once a nanosecond after it, and checks that the first strobe moves by one cycle. A second bench instance starts from a different power-up phase, so the claim that the phase realigns is tested by comparing the two instances half-cycle by half-cycle after each shared pulse.

// File: rtl/clkalign_pkg.sv
package clkalign_pkg;

  // Level the output clock rests at while held.
  function automatic logic park_level(input logic ddr, input logic inv);
    return ddr ^ inv;
  endfunction

  // The longer restart wait applies only to demux DDR at zero phase.
  function automatic logic needs_long_wait(input logic ddr, input logic demux, input logic inv);
    return demux & ddr & ~inv;
  endfunction

  // Low phase-counter bits that must be zero for a period start.
  function automatic logic [1:0] phase_mask(input logic ddr, input logic demux);
    if (!demux) return 2'b00;
    return ddr ? 2'b11 : 2'b01;
  endfunction

endpackage

// File: rtl/release_capture.sv
module release_capture (
  input  logic smp_clk,
  input  logic rst_go,
  output logic pending
);
  logic pend_q = 1'b0;

  // Set at once by the gated reset, cleared only on a falling edge.
  always_ff @(negedge smp_clk or posedge rst_go) begin
    if (rst_go) pend_q <= 1'b1;
    else        pend_q <= 1'b0;
  end

  assign pending = pend_q;
endmodule

// File: rtl/restart_timer.sv
module restart_timer #(
  parameter int DLY_LONG  = 5,
  parameter int DLY_SHORT = 4
) (
  input  logic smp_clk,
  input  logic rst_go,
  input  logic pending,
  input  logic long_sel,
  output logic running
);
  localparam int HW = $clog2(DLY_LONG + 1);
  localparam logic [HW-1:0] LIM_L = HW'(DLY_LONG);
  localparam logic [HW-1:0] LIM_S = HW'(DLY_SHORT);

  logic [HW-1:0] hold_q = '0;
  logic [HW-1:0] limit;

  assign limit = long_sel ? LIM_L : LIM_S;

  always_ff @(posedge smp_clk or posedge rst_go) begin
    if (rst_go)                       hold_q <= '0;
    else if (!pending && hold_q < LIM_L) hold_q <= hold_q + 1'b1;
  end

  assign running = (hold_q >= limit);

  AST_RESTART_WAIT: assert property (@(posedge smp_clk) disable iff (rst_go)
    $rose(running) |-> !$past(pending, 4)) else $error("restart before wait"); // R3
endmodule

// File: rtl/phase_divider.sv
module phase_divider
  import clkalign_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int POWERUP_CNT = 0
) (
  input  logic smp_clk,
  input  logic rst_go,
  input  logic running,
  input  logic gated,
  input  logic mode_ddr,
  input  logic mode_demux,
  input  logic edge_sel,
  output logic dclk,
  output logic strobe
);
  logic [CNT_W-1:0] cnt_q = CNT_W'(POWERUP_CNT);
  logic             phase_bit;
  logic [1:0]       mask;
  logic             park;

  always_ff @(posedge smp_clk or posedge rst_go) begin
    if (rst_go)       cnt_q <= '0;
    else if (running) cnt_q <= cnt_q + 1'b1;
  end

  assign phase_bit = mode_ddr ? cnt_q[1] : cnt_q[0];
  assign mask      = phase_mask(mode_ddr, mode_demux);
  assign park      = park_level(mode_ddr, edge_sel);

  always_comb begin
    if (!running || gated) dclk = park;
    else if (mode_demux)   dclk = phase_bit ^ edge_sel;
    else                   dclk = smp_clk ^ edge_sel;
  end

  assign strobe = running & ~gated & ((cnt_q[1:0] & mask) == 2'b00);
endmodule

// File: rtl/cal_err_flag.sv
module cal_err_flag (
  input  logic smp_clk,
  input  logic align_rst,
  input  logic cal_busy,
  input  logic err_clr,
  output logic cal_err
);
  logic err_q = 1'b0;

  always_ff @(posedge smp_clk) begin
    err_q <= (err_q & ~err_clr) | (align_rst & cal_busy);
  end

  assign cal_err = err_q;

  AST_ERR_STICKY: assert property (@(posedge smp_clk) disable iff (err_clr)
    cal_err |=> cal_err) else $error("error flag dropped"); // R8
endmodule

// File: rtl/clock_align_sync.sv
module clock_align_sync
  import clkalign_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int POWERUP_CNT = 0,
  parameter int DLY_LONG    = 5,
  parameter int DLY_SHORT   = 4
) (
  input  logic smp_clk,
  input  logic align_rst,
  input  logic mode_ddr,
  input  logic mode_demux,
  input  logic edge_sel,
  input  logic cal_busy,
  input  logic keep_running,
  input  logic err_clr,
  output logic dclk_out,
  output logic word_valid,
  output logic cal_err
);
  logic rst_go;
  logic pending;
  logic running;
  logic gated;
  logic long_sel;

  // Reset is honoured only outside calibration.
  assign rst_go   = align_rst & ~cal_busy;
  assign gated    = cal_busy & ~keep_running;
  assign long_sel = needs_long_wait(mode_ddr, mode_demux, edge_sel);

  release_capture u_rel (
    .smp_clk (smp_clk),
    .rst_go  (rst_go),
    .pending (pending)
  );

  restart_timer #(.DLY_LONG(DLY_LONG), .DLY_SHORT(DLY_SHORT)) u_tmr (
    .smp_clk  (smp_clk),
    .rst_go   (rst_go),
    .pending  (pending),
    .long_sel (long_sel),
    .running  (running)
  );

  phase_divider #(.CNT_W(CNT_W), .POWERUP_CNT(POWERUP_CNT)) u_div (
    .smp_clk    (smp_clk),
    .rst_go     (rst_go),
    .running    (running),
    .gated      (gated),
    .mode_ddr   (mode_ddr),
    .mode_demux (mode_demux),
    .edge_sel   (edge_sel),
    .dclk       (dclk_out),
    .strobe     (word_valid)
  );

  cal_err_flag u_err (
    .smp_clk   (smp_clk),
    .align_rst (align_rst),
    .cal_busy  (cal_busy),
    .err_clr   (err_clr),
    .cal_err   (cal_err)
  );

  AST_PARK_IN_RESET: assert property (@(posedge smp_clk) disable iff (!align_rst)
    rst_go |-> (dclk_out == park_level(mode_ddr, edge_sel)) && !word_valid)
    else $error("not parked in reset"); // R1

  AST_CAL_PARK: assert property (@(posedge smp_clk) disable iff (rst_go)
    gated |-> (dclk_out == park_level(mode_ddr, edge_sel)) && !word_valid)
    else $error("not parked in calibration"); // R6

  AST_STROBE_SPACING: assert property (@(posedge smp_clk) disable iff (rst_go)
    (word_valid && mode_demux) |=> (!word_valid || !mode_demux))
    else $error("strobe twice in a row"); // R5

  AST_IGNORE_IN_CAL: assert property (@(posedge smp_clk) disable iff (!cal_busy)
    running |=> running || !$stable({mode_ddr, mode_demux, edge_sel}))
    else $error("clock stopped during calibration"); // R7
endmodule

// File: tb/test_clock_align_sync.sv
`timescale 1ns/1ps
module test_clock_align_sync;
  logic clk = 1'b0, arst = 1'b0, ddr = 1'b0, dmx = 1'b1, edg = 1'b0;
  logic cal = 1'b0, keep = 1'b0, eclr = 1'b0;
  logic oa, sa, ea, ob, sb, eb;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clock_align_sync #(.POWERUP_CNT(0)) i_clock_align_sync (
    .smp_clk(clk), .align_rst(arst), .mode_ddr(ddr), .mode_demux(dmx),
    .edge_sel(edg), .cal_busy(cal), .keep_running(keep), .err_clr(eclr),
    .dclk_out(oa), .word_valid(sa), .cal_err(ea));

  clock_align_sync #(.POWERUP_CNT(3)) i_clock_align_sync_b (
    .smp_clk(clk), .align_rst(arst), .mode_ddr(ddr), .mode_demux(dmx),
    .edge_sel(edg), .cal_busy(cal), .keep_running(keep), .err_clr(eclr),
    .dclk_out(ob), .word_valid(sb), .cal_err(eb));

  // {ddr, demux, edge_sel, expected restart wait}
  localparam logic [5:0] VEC [7] = '{
    {1'b0, 1'b1, 1'b0, 3'd4}, {1'b0, 1'b1, 1'b1, 3'd4},
    {1'b1, 1'b1, 1'b0, 3'd5}, {1'b1, 1'b1, 1'b1, 3'd4},
    {1'b0, 1'b0, 1'b0, 3'd4}, {1'b1, 1'b0, 1'b1, 3'd4},
    {1'b1, 1'b0, 1'b0, 3'd4}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_row(input logic d, input logic m, input logic e, input int dly);
    logic park;
    int msk, j;
    logic exp_s, exp_hi, exp_lo;
    ddr = d; dmx = m; edg = e;
    park = d ^ e;
    msk = m ? (d ? 3 : 1) : 0;
    @(posedge clk); #3 arst = 1'b1;
    #1 chk("R1 async park a", oa, park); chk("R1 async park b", ob, park);
    @(posedge clk); #2 chk("R1 park high phase", oa, park); chk("R1 strobe low", sa, 0);
    #5 chk("R1 park low phase", oa, park);
    @(posedge clk); #1 arst = 1'b0;
    for (int k = 1; k <= dly + 8; k++) begin
      @(posedge clk); #2;
      j = k - dly;
      exp_s  = (k >= dly) && ((j & msk) == 0);
      exp_hi = (k < dly) ? park : (m ? (((d ? (j >> 1) : j) & 1) ^ e) : ~e);
      exp_lo = (k < dly) ? park : (m ? exp_hi : e);
      if (k == dly - 1 || k == dly) chk("R3 restart point", sa, exp_s);
      else chk("R5 strobe", sa, exp_s);
      chk("R4 clock high half", oa, exp_hi);
      chk("R9 clock match", ob, oa);
      chk("R9 strobe match", sb, sa);
      #5;
      chk("R4 clock low half", oa, exp_lo);
      chk("R9 clock match low", ob, oa);
    end
  endtask

  task automatic release_at(input int off, input int first);
    ddr = 1'b0; dmx = 1'b1; edg = 1'b0;
    @(posedge clk); #3 arst = 1'b1;
    @(posedge clk); #(off) arst = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); #2;
      chk("R2 capture edge", sa, (k >= first) && (((k - first) & 1) == 0));
    end
  endtask

  initial begin
    int tog;
    logic prev;
    #2 chk("R8 reset state", ea, 0);
    chk("R8 reset state b", eb, 0);
    foreach (VEC[i]) run_row(VEC[i][5], VEC[i][4], VEC[i][3], int'(VEC[i][2:0]));

    // R2: release 1 ns before vs 1 ns after a falling edge
    release_at(4, 4);
    release_at(6, 5);

    // R6: calibration parks the clock unless keep_running
    run_row(1'b0, 1'b1, 1'b0, 4);
    @(posedge clk); #3 cal = 1'b1; keep = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #2;
      chk("R6 parked in cal", oa, 0);
      chk("R6 strobe low in cal", sa, 0);
    end
    keep = 1'b1;
    tog = 0; prev = oa;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #2;
      if (oa !== prev) tog++;
      prev = oa;
    end
    chk("R6 runs with keep", tog > 0, 1);

    // R7: reset during calibration ignored, R8 flag set
    @(posedge clk); #3 arst = 1'b1;
    tog = 0; prev = oa;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      if (oa !== prev) tog++;
      prev = oa;
    end
    arst = 1'b0;
    chk("R7 clock not stopped", tog > 0, 1);
    chk("R9 match after ignored reset", ob, oa);
    chk("R8 flag set", ea, 1);

    // R8: clear, then set-wins
    @(posedge clk); #3 eclr = 1'b1;
    @(posedge clk); #1 eclr = 1'b0;
    #1 chk("R8 cleared", ea, 0);
    @(posedge clk); #3 eclr = 1'b1; arst = 1'b1;
    @(posedge clk); #1 eclr = 1'b0; arst = 1'b0;
    #1 chk("R8 set wins over clear", ea, 1);
    cal = 1'b0; keep = 1'b0;
    repeat (3) @(posedge clk);
    #2 chk("R8 sticky", ea, 1);
    chk("R8 sticky b", eb, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule